// File: doc/BRIEF.md
# Serial DAC Front-End with Multi-Strobe Shift Clock

This block is the digital input side of a 12-bit serial-input converter. A 12-bit input shift register collects one serial data bit for each qualifying strobe event, most significant bit first. Four strobe pins can supply that event. Three of them act on a rising edge and one acts on a falling edge. All four are merged into one effective shift clock, so any strobe held in its active level blocks the others.

A transfer copies the shift register into a 12-bit holding register that drives the converter code. A transfer needs two active-low load pins to be low together. An active-low clear zeroes the holding register at once, whatever the other pins are doing. The clear leaves the shift register alone.

Every pin is brought onto the system clock through a two-flop synchronizer, and edges are detected after that stage. Both registers are visible as parallel outputs. A 4-bit count of the bits shifted since the last transfer is also provided.

Top module: `sdac_front`

## Requirements
- R1: The shift register is 12 bits wide and fills most significant bit first. Each shift moves bits one place toward bit 11 and puts the new data bit into bit 0, so after 12 shifts the first bit sent sits in bit 11.
- R2: Strobe pins `stb_i[0]`, `stb_i[1]` and `stb_i[3]` request a shift on their rising edge. Pin `stb_i[2]` requests a shift on its falling edge. The data bit taken is the synchronized `sdi_i` in the same system cycle as that edge.
- R3: A shift occurs only when the effective strobe goes from 0 to 1. The effective strobe is the OR of `stb_i[0]`, `stb_i[1]`, `stb_i[3]` and the inverse of `stb_i[2]`. While `stb_i[0]`, `stb_i[1]` or `stb_i[3]` is held high, or `stb_i[2]` is held low, edges on the other strobes shift nothing. Releasing the held strobe shifts nothing either.
- R4: The holding register takes the shift register value only in cycles where both `ld_a_ni` and `ld_b_ni` are low after synchronization. If either load pin is high, the holding register keeps its value.
- R5: While both load pins stay low, the holding register tracks the shift register every system cycle, so bits shifted in during a held load reach `dac_q_o`.
- R6: A low level on `clr_ni` zeroes `dac_q_o` immediately, without waiting for a clock. Clear takes priority over load. The holding register stays zero until the release of the clear has passed the synchronizer.
- R7: Clear leaves `shift_q_o` and `shift_cnt_o` unchanged.
- R8: After reset, `shift_q_o`, `dac_q_o` and `shift_cnt_o` are zero, and no shift occurs while the strobes rest at their inactive levels (`stb_i` = 4'b0100).
- R9: `shift_cnt_o` goes up by one on each shift and stops at 12. It reads zero in every cycle that performs a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdi_i | input | 1 | Serial data pin |
| stb_i | input | 4 | Strobe pins; bit 2 acts on its falling edge, the other bits on their rising edge |
| ld_a_ni | input | 1 | First active-low load pin |
| ld_b_ni | input | 1 | Second active-low load pin |
| clr_ni | input | 1 | Asynchronous active-low clear of the holding register |
| shift_q_o | output | 12 | Input shift register contents |
| dac_q_o | output | 12 | Holding register contents (converter code) |
| shift_cnt_o | output | 4 | Bits shifted since the last transfer, saturating at 12 |

## Verification
The assertions assume that every pin holds steady long enough to cross the two-flop synchronizer. They also assume that the clear pin does not pulse low and back high between two system clock edges, since a pulse that short would clear the holding register without the clocked checks ever seeing it low. The bench changes pins only shortly after a falling clock edge and holds each strobe level for three system cycles. Load and clear levels are held for several cycles.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  parameter int unsigned DATA_W      = 12;
  parameter int unsigned NUM_STB     = 4;
  parameter int unsigned SYNC_STAGES = 2;
  // strobes that act on their falling edge
  parameter logic [NUM_STB-1:0] STB_FALL_MASK = 4'b0100;
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  // synchronized bundle: {sdi, stb, ld_a, ld_b, clr}
  localparam int unsigned BUS_W = NUM_STB + 4;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdac_strobe_det.sv
module sdac_strobe_det #(
  parameter int unsigned NUM_STB = 4,
  parameter logic [NUM_STB-1:0] FALL_MASK = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_STB-1:0] stb_s_i,
  output logic               shift_en_o
);
  logic eff, eff_q;

  // per-pin polarity folding, then OR: any active level holds the clock high
  assign eff = |(stb_s_i ^ FALL_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eff_q <= 1'b1;  // start inhibited
    else         eff_q <= eff;
  end

  assign shift_en_o = eff & ~eff_q;
endmodule

// File: rtl/sdac_shift_reg.sv
module sdac_shift_reg #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              sdi_s_i,
  input  logic              load_en_i,
  output logic [DATA_W-1:0] q_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_o <= '0;
    else if (shift_en_i) q_o <= {q_o[DATA_W-2:0], sdi_s_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_o <= '0;
    else if (load_en_i)                      cnt_o <= '0;
    else if (shift_en_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sdac_hold_reg.sv
module sdac_hold_reg #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              clr_s_i,
  input  logic              load_en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  // raw pin clears at once; synchronized copy holds zero until release settles
  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
    if (!rst_ni)        q_o <= '0;
    else if (!clr_ni)   q_o <= '0;
    else if (!clr_s_i)  q_o <= '0;
    else if (load_en_i) q_o <= d_i;
  end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sdi_i,
  input  logic [NUM_STB-1:0] stb_i,
  input  logic               ld_a_ni,
  input  logic               ld_b_ni,
  input  logic               clr_ni,
  output logic [DATA_W-1:0]  shift_q_o,
  output logic [DATA_W-1:0]  dac_q_o,
  output logic [CNT_W-1:0]   shift_cnt_o
);
  localparam logic [BUS_W-1:0] BUS_RST = {1'b0, STB_FALL_MASK, 3'b111};

  logic [BUS_W-1:0]   bus_s;
  logic               sdi_s, ld_a_s, ld_b_s, clr_s;
  logic [NUM_STB-1:0] stb_s;
  logic               shift_en, load_en;

  sdac_sync #(
    .W      (BUS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(BUS_RST)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdi_i, stb_i, ld_a_ni, ld_b_ni, clr_ni}),
    .q_o   (bus_s)
  );

  assign {sdi_s, stb_s, ld_a_s, ld_b_s, clr_s} = bus_s;
  assign load_en = ~ld_a_s & ~ld_b_s;

  sdac_strobe_det #(
    .NUM_STB  (NUM_STB),
    .FALL_MASK(STB_FALL_MASK)
  ) i_stb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_s_i   (stb_s),
    .shift_en_o(shift_en)
  );

  sdac_shift_reg #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(shift_en),
    .sdi_s_i   (sdi_s),
    .load_en_i (load_en),
    .q_o       (shift_q_o),
    .cnt_o     (shift_cnt_o)
  );

  sdac_hold_reg #(
    .DATA_W(DATA_W)
  ) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_ni   (clr_ni),
    .clr_s_i  (clr_s),
    .load_en_i(load_en),
    .d_i      (shift_q_o),
    .q_o      (dac_q_o)
  );
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk
  import sdac_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_ni,
  input logic              clr_s,
  input logic              shift_en,
  input logic              load_en,
  input logic [DATA_W-1:0] shift_q_o,
  input logic [DATA_W-1:0] dac_q_o,
  input logic [CNT_W-1:0]  shift_cnt_o
);
  // R1
  shift_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en |=> shift_q_o[DATA_W-1:1] == $past(shift_q_o[DATA_W-2:0]));

  // R3
  no_edge_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en |=> $stable(shift_q_o));

  // R4
  dac_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en && clr_s) |=> (!clr_ni || $stable(dac_q_o)));

  // R5
  dac_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en && clr_s) |=> (!clr_ni || dac_q_o == $past(shift_q_o)));

  // R6
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> dac_q_o == '0);

  // R9
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_cnt_o <= CNT_W'(DATA_W));

  // R9
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |=> shift_cnt_o == '0);
endmodule

bind sdac_front sdac_front_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_ni     (clr_ni),
  .clr_s      (clr_s),
  .shift_en   (shift_en),
  .load_en    (load_en),
  .shift_q_o  (shift_q_o),
  .dac_q_o    (dac_q_o),
  .shift_cnt_o(shift_cnt_o)
);

// File: tb/test_sdac_front.sv
`timescale 1ns/1ps
module test_sdac_front;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sdi = 1'b0;
  logic [3:0]  stb = 4'b0100;
  logic        ld_a_n = 1'b1, ld_b_n = 1'b1, clr_n = 1'b1;
  logic [11:0] shift_q, dac_q;
  logic [3:0]  cnt;

  int checks = 0, errors = 0;
  bit run = 1'b0;

  always #4 clk = ~clk;

  sdac_front i_sdac_front (
    .clk_i(clk), .rst_ni(rst_ni), .sdi_i(sdi), .stb_i(stb),
    .ld_a_ni(ld_a_n), .ld_b_ni(ld_b_n), .clr_ni(clr_n),
    .shift_q_o(shift_q), .dac_q_o(dac_q), .shift_cnt_o(cnt)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: pins seen two clock edges late
  logic [7:0] hist[$];
  int m_shift = 0, m_dac = 0, m_cnt = 0;
  bit m_eff_prev = 1'b1;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist.delete();
      m_shift = 0; m_dac = 0; m_cnt = 0; m_eff_prev = 1'b1;
    end else begin
      logic [7:0] s;
      bit eff, load;
      int old_shift;
      hist.push_back({sdi, stb, ld_a_n, ld_b_n, clr_n});
      if (hist.size() > 3) void'(hist.pop_front());
      s = (hist.size() == 3) ? hist[0] : 8'b0_0100_111;
      eff = s[3] | s[4] | !s[5] | s[6];
      load = !s[2] && !s[1];
      old_shift = m_shift;
      if (eff && !m_eff_prev) begin
        m_shift = ((m_shift << 1) | int'(s[7])) & 12'hfff;
        if (!load && m_cnt < 12) m_cnt++;
      end
      if (load) m_cnt = 0;
      if (!clr_n || !s[0]) m_dac = 0;
      else if (load) m_dac = old_shift;
      m_eff_prev = eff;
    end
  end

  always @(negedge clk) begin
    if (run) begin
      chk("R1/R2/R3 shift per cycle", shift_q, m_shift);
      chk("R4/R5/R6 dac per cycle", dac_q, clr_n ? m_dac : 0);
      chk("R9 count per cycle", cnt, m_cnt);
    end
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic send_bit(int idx, bit b);
    wait_cyc(1);
    sdi = b;
    stb[idx] = ~stb[idx];
    wait_cyc(3);
    stb[idx] = ~stb[idx];
    wait_cyc(3);
  endtask

  task automatic send_word(int idx, logic [11:0] w);
    for (int i = 11; i >= 0; i--) send_bit(idx, w[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R8 reset state
    chk("R8 shift at reset", shift_q, 0);
    chk("R8 dac at reset", dac_q, 0);
    chk("R8 count at reset", cnt, 0);
    rst_ni = 1'b1;
    run = 1'b1;
    wait_cyc(6);
    chk("R8 no spurious shift", shift_q, 0);
    chk("R8 no spurious count", cnt, 0);

    // R1 R2 rising strobe 0
    send_word(0, 12'ha5c);
    wait_cyc(2);
    chk("R1 word msb first", shift_q, 12'ha5c);
    chk("R9 count at 12", cnt, 12);

    // R4 transfer
    ld_a_n = 0; ld_b_n = 0;
    wait_cyc(4);
    ld_a_n = 1; ld_b_n = 1;
    wait_cyc(4);
    chk("R4 transfer", dac_q, 12'ha5c);
    chk("R9 count cleared by transfer", cnt, 0);

    // R2 falling strobe 2, with only one load low
    ld_a_n = 0;
    send_word(2, 12'h3c9);
    wait_cyc(2);
    chk("R2 falling strobe word", shift_q, 12'h3c9);
    chk("R4 one load low holds", dac_q, 12'ha5c);
    ld_a_n = 1; ld_b_n = 0;
    wait_cyc(6);
    chk("R4 other load low holds", dac_q, 12'ha5c);
    ld_b_n = 1;

    // R2 rotating strobes
    begin
      logic [11:0] w = 12'h5a3;
      for (int i = 11; i >= 0; i--) send_bit(i % 4, w[i]);
    end
    wait_cyc(2);
    chk("R2 mixed strobe word", shift_q, 12'h5a3);

    // R5 held load follows shifts
    ld_a_n = 0; ld_b_n = 0;
    wait_cyc(4);
    chk("R5 held load copy", dac_q, 12'h5a3);
    send_bit(3, 1); send_bit(1, 0); send_bit(0, 1); send_bit(2, 1);
    wait_cyc(4);
    chk("R5 shift passes through", dac_q, 12'ha3b);
    ld_a_n = 1; ld_b_n = 1;
    wait_cyc(4);

    // R3 inhibit by held strobe 1 high
    stb[1] = 1'b1;
    wait_cyc(4);
    chk("R3 hold start shifts once", shift_q, 12'h477);
    send_bit(3, 0); send_bit(0, 0); send_bit(2, 0);
    chk("R3 inhibited by high strobe", shift_q, 12'h477);
    stb[1] = 1'b0;
    wait_cyc(5);
    chk("R3 release no shift", shift_q, 12'h477);
    // inhibit by strobe 2 held low
    stb[2] = 1'b0;
    wait_cyc(4);
    chk("R3 low strobe start shifts once", shift_q, 12'h8ee);
    send_bit(0, 1); send_bit(3, 1);
    chk("R3 inhibited by low strobe", shift_q, 12'h8ee);
    stb[2] = 1'b1;
    wait_cyc(5);
    chk("R3 release high no shift", shift_q, 12'h8ee);
    chk("R9 count two shifts", cnt, 2);

    // R6 R7 clear with priority over load
    ld_a_n = 0; ld_b_n = 0;
    wait_cyc(4);
    chk("R4 dac before clear", dac_q, 12'h8ee);
    clr_n = 1'b0;
    #1;
    chk("R6 immediate clear", dac_q, 0);
    send_bit(0, 1);
    wait_cyc(2);
    chk("R6 clear beats load", dac_q, 0);
    chk("R7 shift kept during clear", shift_q, 12'h1dd);
    ld_a_n = 1; ld_b_n = 1;
    wait_cyc(4);
    send_bit(3, 0);
    wait_cyc(2);
    chk("R7 count kept during clear", cnt, 1);
    clr_n = 1'b1;
    wait_cyc(1);
    chk("R6 zero during release sync", dac_q, 0);
    ld_a_n = 0; ld_b_n = 0;
    wait_cyc(5);
    chk("R6 load after release", dac_q, 12'h3ba);
    ld_a_n = 1; ld_b_n = 1;
    wait_cyc(4);

    // R9 saturation
    for (int i = 0; i < 14; i++) send_bit(i % 4, 1'b1);
    wait_cyc(2);
    chk("R9 count saturates", cnt, 12);
    chk("R1 all ones", shift_q, 12'hfff);

    run = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule